// File: doc/BRIEF.md
# External Clock Frequency Monitor

This block supervises an external clock that can serve as the PWM time base of a multi-channel output driver. The external clock passes through a two-stage synchronizer. Its rising edges are counted over a measurement window made of a fixed number of reference ticks from the internal clock domain. When a window closes, the edge total is compared against a programmable lower and upper bound. A total outside those bounds is a failure, and so is a window in which no edge arrived. Either one sets the clock-fail flag.

The fail flag also acts on the outputs. While it is set, the PWM-driven levels are discarded, and each output channel follows its own static enable bit instead. The flag clears by itself once two windows in a row measure in range. Monitoring runs only while the enable input is high, which indicates that the external clock is the selected PWM source. Dropping that input clears all measurement state and the flag.

Top module: `extclk_freq_monitor`

## Requirements
- R1: After reset the fail flag is 0 and every output channel follows its PWM-driven input.
- R2: The external clock is sampled by two flip-flops, and each low-to-high transition of the synchronized level is counted exactly once.
- R3: A window ends on the WIN_LEN-th reference tick since the previous window end, or since monitoring was enabled. The fail flag is set only at a window end.
- R4: A window total below the programmed minimum sets the fail flag.
- R5: A window total above the programmed maximum sets the fail flag.
- R6: A window with zero edges sets the fail flag, even when the programmed minimum is 0.
- R7: A set fail flag clears at the end of the second consecutive in-range window. Any out-of-range window restarts that count.
- R8: While the fail flag is 1, output channel i equals enable bit i. While it is 0, output channel i equals PWM input bit i.
- R9: While monitoring is disabled, the fail flag is 0 from the next cycle on, and the window and edge counts restart from zero.
- R10: The edge count saturates at 2^CNT_W-1 and never wraps within a window.
- R11: A cycle without a reference tick does not advance the window position. Edges are still counted in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | External PWM clock, asynchronous to clk |
| mon_en_i | input | 1 | Monitoring enable (external clock selected) |
| ref_tick_i | input | 1 | Reference tick that advances the window |
| cnt_min_i | input | CNT_W | Lowest acceptable edge total per window |
| cnt_max_i | input | CNT_W | Highest acceptable edge total per window |
| pwm_drv_i | input | N_CH | PWM-driven channel levels |
| chan_en_i | input | N_CH | Static per-channel enable levels for fallback |
| clk_fail_o | output | 1 | Clock failure flag |
| out_o | output | N_CH | Channel outputs after fallback selection |

## Verification
A window counter that is off by one shows up as a flag transition shifted by one cycle from the reference model, the first time a window closes on a failing or recovering clock. That comparison happens in the same cycle, within one window of the fault. An edge counter that drops, duplicates or wraps edges moves the total across a bound chosen close to the expected count. The flag then goes wrong at the next window end. The sparse-tick case with a clock toggling every cycle drives the total past the counter's range, which tests saturation. A recovery counter that is wrong clears the flag one window early or late, and the outputs switch between PWM and enable levels at the same moment.

// File: rtl/fm_pkg.sv
`timescale 1ns/1ps
package fm_pkg;

  // saturating add of a single-bit increment
  function automatic int unsigned sat_inc(int unsigned acc, logic inc, int unsigned cap);
    int unsigned nxt;
    nxt = acc + (inc ? 1 : 0);
    return (nxt > cap) ? cap : nxt;
  endfunction

  // true when a window total must be treated as a clock failure
  function automatic logic total_bad(int unsigned total, int unsigned lo, int unsigned hi);
    return (total == 0) || (total < lo) || (total > hi);
  endfunction

endpackage

// File: rtl/fm_sync.sv
`timescale 1ns/1ps
module fm_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic meta_q, stab_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      stab_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
      last_q <= stab_q;
    end
  end

  assign rise_o = stab_q & ~last_q;

  // R2: one pulse per synchronized rising transition
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/fm_window.sv
`timescale 1ns/1ps
module fm_window #(
  parameter int unsigned WIN_LEN = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_en,
  input  logic tick,
  output logic win_end_o
);
  localparam int unsigned WW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [WW-1:0] LAST = WW'(WIN_LEN - 1);

  logic [WW-1:0] pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (!mon_en) begin
      pos_q <= '0;
    end else if (tick) begin
      pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
    end
  end

  assign win_end_o = mon_en & tick & (pos_q == LAST);

  // R11: no tick, no advance
  a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_en && !tick) |=> $stable(pos_q));
  // R9: disabled monitor restarts the window
  a_r9_window_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en |=> (pos_q == '0));
endmodule

// File: rtl/fm_judge.sv
`timescale 1ns/1ps
module fm_judge #(
  parameter int unsigned CNT_W   = 10,
  parameter int unsigned CLR_WIN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mon_en,
  input  logic             rise,
  input  logic             win_end,
  input  logic [CNT_W-1:0] lim_lo,
  input  logic [CNT_W-1:0] lim_hi,
  output logic             fail_o
);
  localparam int unsigned CAP = (2 ** CNT_W) - 1;
  localparam int unsigned GW  = $clog2(CLR_WIN + 1);
  localparam logic [GW-1:0] GOOD_LAST = GW'(CLR_WIN - 1);

  logic [CNT_W-1:0] edges_q;
  logic [GW-1:0]    good_q;
  logic             fail_q;
  logic [CNT_W-1:0] total;
  logic             bad;

  assign total = CNT_W'(fm_pkg::sat_inc(32'(edges_q), rise, CAP));
  assign bad   = fm_pkg::total_bad(32'(total), 32'(lim_lo), 32'(lim_hi));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edges_q <= '0;
      good_q  <= '0;
      fail_q  <= 1'b0;
    end else if (!mon_en) begin
      edges_q <= '0;
      good_q  <= '0;
      fail_q  <= 1'b0;
    end else if (win_end) begin
      edges_q <= '0;
      if (bad) begin
        fail_q <= 1'b1;
        good_q <= '0;
      end else if (fail_q) begin
        if (good_q == GOOD_LAST) begin
          fail_q <= 1'b0;
          good_q <= '0;
        end else begin
          good_q <= good_q + 1'b1;
        end
      end else begin
        good_q <= '0;
      end
    end else begin
      edges_q <= total;
    end
  end

  assign fail_o = fail_q;

  // R3: failure is only ever raised when a window closes
  a_r3_raise_at_window_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_q) |-> $past(win_end));
  // R7: recovery only on an in-range window end
  a_r7_clear_on_good_window: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fail_q) && $past(mon_en)) |-> ($past(win_end) && !$past(bad)));
  // R9: disabled monitor shows no failure
  a_r9_disabled_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en |=> !fail_q);
  // R10: a full count holds until the window closes
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_en && !win_end && edges_q == CNT_W'(CAP)) |=> (edges_q == CNT_W'(CAP)));
endmodule

// File: rtl/extclk_freq_monitor.sv
`timescale 1ns/1ps
module extclk_freq_monitor #(
  parameter int unsigned N_CH    = 4,
  parameter int unsigned WIN_LEN = 1024,
  parameter int unsigned CNT_W   = 10,
  parameter int unsigned CLR_WIN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk_i,
  input  logic             mon_en_i,
  input  logic             ref_tick_i,
  input  logic [CNT_W-1:0] cnt_min_i,
  input  logic [CNT_W-1:0] cnt_max_i,
  input  logic [N_CH-1:0]  pwm_drv_i,
  input  logic [N_CH-1:0]  chan_en_i,
  output logic             clk_fail_o,
  output logic [N_CH-1:0]  out_o
);
  logic ext_rise;
  logic win_end;
  logic fail;

  fm_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (ext_clk_i),
    .rise_o  (ext_rise)
  );

  fm_window #(.WIN_LEN(WIN_LEN)) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .mon_en    (mon_en_i),
    .tick      (ref_tick_i),
    .win_end_o (win_end)
  );

  fm_judge #(.CNT_W(CNT_W), .CLR_WIN(CLR_WIN)) u_judge (
    .clk     (clk),
    .rst_n   (rst_n),
    .mon_en  (mon_en_i),
    .rise    (ext_rise),
    .win_end (win_end),
    .lim_lo  (cnt_min_i),
    .lim_hi  (cnt_max_i),
    .fail_o  (fail)
  );

  // per-channel fallback selection
  for (genvar g = 0; g < N_CH; g++) begin : g_chan
    assign out_o[g] = fail ? chan_en_i[g] : pwm_drv_i[g];
  end

  assign clk_fail_o = fail;

  // R1: nothing is flagged straight out of reset
  a_r1_reset_clear: assert property (@(posedge clk)
    $rose(rst_n) |-> !clk_fail_o);
endmodule

// File: tb/extclk_freq_monitor_bench.sv
`timescale 1ns/1ps
module extclk_freq_monitor_bench;
  localparam int N_CH = 4;
  localparam int WIN  = 1024;
  localparam int CW   = 10;
  localparam int CAP  = 1023;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_clk = 1'b0;
  logic mon_en = 1'b0;
  logic tick = 1'b0;
  logic [CW-1:0] cmin = 10'd100;
  logic [CW-1:0] cmax = 10'd150;
  logic [N_CH-1:0] pwm_drv = '0;
  logic [N_CH-1:0] chan_en = 4'b1010;
  logic clk_fail;
  logic [N_CH-1:0] outs;

  int per = 8;
  int tick_div = 1;
  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  string tag = "R1";

  // behavioural reference state
  int p1, p2, p3, m_wc, m_ec, m_good;
  bit m_fail;

  always #2.5 clk = ~clk;

  extclk_freq_monitor u_extclk_freq_monitor (
    .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk), .mon_en_i(mon_en),
    .ref_tick_i(tick), .cnt_min_i(cmin), .cnt_max_i(cmax),
    .pwm_drv_i(pwm_drv), .chan_en_i(chan_en),
    .clk_fail_o(clk_fail), .out_o(outs)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // stimulus generator
  always @(negedge clk) begin
    if (!rst_n) begin
      ext_clk <= 1'b0;
      tick    <= 1'b0;
    end else begin
      cyc     <= cyc + 1;
      ext_clk <= (per == 0) ? 1'b0 : ((cyc % per) < (per / 2));
      tick    <= ((cyc % tick_div) == 0);
      pwm_drv <= N_CH'(cyc >> 2);
    end
  end

  // reference model, one step per rising edge
  always @(posedge clk) begin
    int r, tot;
    if (!rst_n) begin
      p1 = 0; p2 = 0; p3 = 0;
      m_wc = 0; m_ec = 0; m_good = 0; m_fail = 0;
    end else begin
      r = (p2 == 1 && p3 == 0) ? 1 : 0;
      p3 = p2; p2 = p1; p1 = int'(ext_clk);
      if (!mon_en) begin
        m_wc = 0; m_ec = 0; m_good = 0; m_fail = 0;
      end else begin
        tot = m_ec + r;
        if (tot > CAP) tot = CAP;
        if (tick && m_wc == WIN - 1) begin
          m_wc = 0;
          m_ec = 0;
          if (tot == 0 || tot < int'(cmin) || tot > int'(cmax)) begin
            m_fail = 1; m_good = 0;
          end else if (m_fail) begin
            m_good++;
            if (m_good >= 2) begin m_fail = 0; m_good = 0; end
          end else begin
            m_good = 0;
          end
        end else begin
          if (tick) m_wc++;
          m_ec = tot;
        end
      end
    end
  end

  // every-cycle comparison, away from the edges; R8 covers the outputs
  always begin
    @(negedge clk);
    #1;
    check(tag, int'(clk_fail), int'(m_fail));
    check("R8", int'(outs), int'(m_fail ? chan_en : pwm_drv));
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
    #1.2;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    run(5);
    check("R1", int'(clk_fail), 0);
    check("R1", int'(outs), int'(pwm_drv));
    rst_n = 1'b1;
    run(3);
    // R2 and R3: nominal clock, 128 edges per window
    tag = "R3"; mon_en = 1'b1; per = 8;
    run(3 * WIN + 50);
    check("R3", int'(clk_fail), 0);
    // R6: stopped clock
    tag = "R6"; per = 0;
    run(2 * WIN + 10);
    check("R6", int'(clk_fail), 1);
    check("R8", int'(outs), int'(chan_en));
    chan_en = 4'b0101;
    run(2);
    check("R8", int'(outs), 4'b0101);
    // R7: recovery after consecutive good windows
    tag = "R7"; per = 8;
    run(4 * WIN);
    check("R7", int'(clk_fail), 0);
    // R5: too fast
    tag = "R5"; per = 4;
    run(2 * WIN + 10);
    check("R5", int'(clk_fail), 1);
    // R7: one good window followed by a bad one keeps the flag
    tag = "R7"; per = 8;
    run(WIN + 20);
    per = 4;
    run(WIN + 20);
    check("R7", int'(clk_fail), 1);
    per = 8;
    run(4 * WIN);
    check("R7", int'(clk_fail), 0);
    // R4: too slow
    tag = "R4"; per = 16;
    run(2 * WIN + 10);
    check("R4", int'(clk_fail), 1);
    // R9: disabling clears the flag on the next cycle
    tag = "R9"; mon_en = 1'b0;
    run(1);
    check("R9", int'(clk_fail), 0);
    run(50);
    check("R9", int'(clk_fail), 0);
    // R6: zero edges fail even with a zero minimum
    tag = "R6"; cmin = '0; per = 0; mon_en = 1'b1;
    run(2 * WIN + 10);
    check("R6", int'(clk_fail), 1);
    // R11: ticks on every other cycle double the window length
    tag = "R11"; cmin = 10'd200; cmax = 10'd300; per = 8; tick_div = 2;
    run(8 * WIN + 20);
    check("R11", int'(clk_fail), 0);
    // R10: sparse ticks, clock toggling each cycle, count saturates at 1023
    tag = "R10"; cmin = 10'd1000; cmax = 10'd1023; per = 2; tick_div = 4;
    run(16 * WIN + 20);
    check("R10", int'(clk_fail), 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule